// File: doc/BRIEF.md
# Local-to-PCI Address Window Translator

This block decides whether an access from a master on the local bus falls inside an address window that must be forwarded to PCI. When it does, the block produces the PCI address for that access. One range mask serves both windows. Its set bits choose which address bits take part in the compare. On a hit, those same bits are replaced by bits from a PCI remap base. Its clear bits give the size of the window, and those address bits pass through unchanged.

Software sets the block up through a simple 32-bit register port. There are four registers: the range mask, a memory window base, an I/O/configuration window base, and a PCI remap base. The low byte of the remap base holds the forwarding enables and the controls for LOCK and read mode. Each local request carries an address and a flag that says whether it is memory or I/O. The hit result, the translated address and the controls are combinational from the current request and the stored register values.

The request port is a valid-qualified stream that never back-pressures. The block takes a request in every cycle, so it has no ready signal. A result is meaningful only while `req_valid` is high.

Top module: `lpx_xlate_top`

## Requirements
- R1: After reset, all four registers read as zero. While the registers hold their reset values, no request hits.
- R2: Register index on `cfg_addr`: 0 is the range mask, 1 is the memory base, 2 is the I/O base, 3 is the remap base. A write with `cfg_wr_en` high takes effect at the next rising clock edge. `cfg_rdata` shows the register selected by `cfg_addr` combinationally.
- R3: In the memory base and the I/O base, bits 15:0 ignore writes and read as zero. Bits 31:16 are stored.
- R4: In the remap base, bits 31:16 store the remap address. Bit 0 is the memory enable, bit 1 the I/O enable, bit 2 the LOCK enable and bit 4 the read mode. Bits 3 and 15:5 read as zero.
- R5: A memory request (`req_is_io`=0) hits when remap bit 0 is set and (addr & mask) equals (memory base & mask).
- R6: An I/O request (`req_is_io`=1) hits when remap bit 1 is set and (addr & mask) equals (I/O base & mask).
- R7: On a hit, `pci_addr` = (addr & ~mask) | (remap address & mask).
- R8: Without a hit, `hit` is 0 and `pci_addr` equals `req_addr`.
- R9: `pci_lock` = `hit` AND remap bit 2. `pci_rd_mode` always equals remap bit 4.
- R10: A decode made in the same cycle as a register write uses the values held before that write.
- R11: All 32 bits of the range mask can be written and read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register index for both write and read |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of the selected register |
| req_valid | input | 1 | Local request present |
| req_is_io | input | 1 | 1 = I/O/configuration request, 0 = memory request |
| req_addr | input | 32 | Local address |
| hit | output | 1 | Request falls in an enabled window |
| pci_addr | output | 32 | Translated address, or the local address if there is no hit |
| pci_lock | output | 1 | LOCK enable for a hitting request |
| pci_rd_mode | output | 1 | PCI read mode control |

## Verification
The assertions assume that `rst_n` is held low for at least one rising edge before any check applies. They also assume that `cfg_addr`, `cfg_wdata` and `cfg_wr_en` are stable around the rising edge. The bench meets both assumptions by changing every input only at the falling edge and by applying reset for several cycles. The assertions also assume that a request's address and type do not depend on the hit result in the same cycle. The bench never feeds an output back into the stimulus, so this holds as well.

// File: rtl/lpx_pkg.sv
package lpx_pkg;
  localparam int NREG   = 4;
  localparam int IDX_W  = $clog2(NREG);

  typedef enum logic [IDX_W-1:0] {
    REG_RANGE   = 2'd0,
    REG_MEMBASE = 2'd1,
    REG_IOBASE  = 2'd2,
    REG_REMAP   = 2'd3
  } reg_idx_e;

  // control bit positions inside the remap register
  localparam int CTL_MEM    = 0;
  localparam int CTL_IO     = 1;
  localparam int CTL_LOCK   = 2;
  localparam int CTL_RDMODE = 4;

  // window kinds, one per decode window
  localparam int NWIN   = 2;
  localparam int WIN_MEM = 0;
  localparam int WIN_IO  = 1;
endpackage

// File: rtl/lpx_regfile.sv
module lpx_regfile
  import lpx_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int BASE_LSB = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [ADDR_W-1:0] wdata,
  output logic [ADDR_W-1:0] rdata,
  output logic [ADDR_W-1:0] range_q,
  output logic [ADDR_W-1:0] mem_base_q,
  output logic [ADDR_W-1:0] io_base_q,
  output logic [ADDR_W-1:0] remap_q
);
  localparam logic [ADDR_W-1:0] HI_MASK  = ~((ADDR_W'(1) << BASE_LSB) - ADDR_W'(1));
  localparam logic [ADDR_W-1:0] CTL_MASK = (ADDR_W'(1) << CTL_MEM) | (ADDR_W'(1) << CTL_IO)
                                         | (ADDR_W'(1) << CTL_LOCK) | (ADDR_W'(1) << CTL_RDMODE);

  function automatic logic [ADDR_W-1:0] keep_bits(input int r);
    case (r)
      int'(REG_RANGE):   keep_bits = '1;
      int'(REG_MEMBASE): keep_bits = HI_MASK;
      int'(REG_IOBASE):  keep_bits = HI_MASK;
      default:           keep_bits = HI_MASK | CTL_MASK;
    endcase
  endfunction

  logic [ADDR_W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) regs[r] <= '0;
    end else if (wr_en) begin
      for (int r = 0; r < NREG; r++)
        if (idx == IDX_W'(r)) regs[r] <= wdata & keep_bits(r);
    end
  end

  assign rdata      = regs[idx];
  assign range_q    = regs[REG_RANGE];
  assign mem_base_q = regs[REG_MEMBASE];
  assign io_base_q  = regs[REG_IOBASE];
  assign remap_q    = regs[REG_REMAP];
endmodule

// File: rtl/lpx_win_match.sv
module lpx_win_match #(
  parameter int ADDR_W = 32
) (
  input  logic              req_valid,
  input  logic              kind_ok,
  input  logic              enable,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] mask,
  output logic              match
);
  logic same;
  assign same  = ((addr ^ base) & mask) == '0;
  assign match = req_valid & kind_ok & enable & same;
endmodule

// File: rtl/lpx_remap.sv
module lpx_remap #(
  parameter int ADDR_W = 32
) (
  input  logic              hit,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] mask,
  input  logic [ADDR_W-1:0] remap_addr,
  output logic [ADDR_W-1:0] out_addr
);
  always_comb begin
    if (hit) out_addr = (addr & ~mask) | (remap_addr & mask);
    else     out_addr = addr;
  end
endmodule

// File: rtl/lpx_xlate_top.sv
module lpx_xlate_top
  import lpx_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int BASE_LSB = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [1:0]        cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] cfg_rdata,
  input  logic              req_valid,
  input  logic              req_is_io,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              hit,
  output logic [ADDR_W-1:0] pci_addr,
  output logic              pci_lock,
  output logic              pci_rd_mode
);
  localparam logic [ADDR_W-1:0] HI_MASK = ~((ADDR_W'(1) << BASE_LSB) - ADDR_W'(1));

  logic [ADDR_W-1:0] range_q, mem_base_q, io_base_q, remap_q, remap_addr;
  logic [NWIN-1:0]   win_hit;
  logic [ADDR_W-1:0] win_base [NWIN];
  logic [NWIN-1:0]   win_en;
  logic [NWIN-1:0]   win_kind;

  lpx_regfile #(.ADDR_W(ADDR_W), .BASE_LSB(BASE_LSB)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .idx(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .range_q(range_q),
    .mem_base_q(mem_base_q), .io_base_q(io_base_q), .remap_q(remap_q)
  );

  assign remap_addr         = remap_q & HI_MASK;
  assign win_base[WIN_MEM]  = mem_base_q;
  assign win_base[WIN_IO]   = io_base_q;
  assign win_en[WIN_MEM]    = remap_q[CTL_MEM];
  assign win_en[WIN_IO]     = remap_q[CTL_IO];
  assign win_kind[WIN_MEM]  = ~req_is_io;
  assign win_kind[WIN_IO]   = req_is_io;

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    lpx_win_match #(.ADDR_W(ADDR_W)) u_match (
      .req_valid(req_valid), .kind_ok(win_kind[w]), .enable(win_en[w]),
      .addr(req_addr), .base(win_base[w]), .mask(range_q), .match(win_hit[w])
    );
  end

  assign hit = |win_hit;

  lpx_remap #(.ADDR_W(ADDR_W)) u_remap (
    .hit(hit), .addr(req_addr), .mask(range_q),
    .remap_addr(remap_addr), .out_addr(pci_addr)
  );

  assign pci_lock    = hit & remap_q[CTL_LOCK];
  assign pci_rd_mode = remap_q[CTL_RDMODE];
endmodule

// File: rtl/lpx_xlate_chk.sv
module lpx_xlate_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr_en,
  input logic [1:0]        cfg_addr,
  input logic [ADDR_W-1:0] cfg_wdata,
  input logic [ADDR_W-1:0] cfg_rdata,
  input logic              req_valid,
  input logic              req_is_io,
  input logic [ADDR_W-1:0] req_addr,
  input logic              hit,
  input logic [ADDR_W-1:0] pci_addr,
  input logic              pci_lock,
  input logic [ADDR_W-1:0] range_q,
  input logic [ADDR_W-1:0] mem_base_q,
  input logic [ADDR_W-1:0] remap_q
);
  // R8: no hit means untouched address
  a_r8_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> pci_addr == req_addr);
  // R7: bits outside the mask never change
  a_r7_low_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ((pci_addr ^ req_addr) & ~range_q) == '0);
  // R5: memory forwarding disabled blocks memory hits
  a_r5_mem_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_is_io && !remap_q[0]) |-> !hit);
  // R6: I/O forwarding disabled blocks I/O hits
  a_r6_io_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_is_io && !remap_q[1]) |-> !hit);
  // R9: lock only with a hit
  a_r9_lock_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    pci_lock |-> hit);
  // R3, R2: memory base write stores only upper half on the next edge
  a_r3_base_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && cfg_addr == 2'd1) |=> mem_base_q == {$past(cfg_wdata[ADDR_W-1:16]), 16'h0000});
  // R4: reserved remap bits read zero
  a_r4_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr == 2'd3) |-> (cfg_rdata & 32'h0000_FFE8) == '0);
  // R1: nothing hits in the cycle right after reset
  a_r1_reset_nohit: assert property (@(posedge clk)
    !rst_n |=> !hit);
endmodule

bind lpx_xlate_top lpx_xlate_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
  .req_is_io(req_is_io), .req_addr(req_addr), .hit(hit), .pci_addr(pci_addr),
  .pci_lock(pci_lock), .range_q(range_q), .mem_base_q(mem_base_q), .remap_q(remap_q)
);

// File: tb/lpx_xlate_top_test.sv
module lpx_xlate_top_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_wr_en = 0;
  logic [1:0]  cfg_addr = 0;
  logic [31:0] cfg_wdata = 0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 0, req_is_io = 0;
  logic [31:0] req_addr = 0;
  logic        hit, pci_lock, pci_rd_mode;
  logic [31:0] pci_addr;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  lpx_xlate_top uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
    .req_is_io(req_is_io), .req_addr(req_addr), .hit(hit), .pci_addr(pci_addr),
    .pci_lock(pci_lock), .pci_rd_mode(pci_rd_mode)
  );

  // {is_io, exp_hit, addr, exp_addr}; mask C0000000, mem 40000000, io C0000000, remap 0
  localparam logic [65:0] VEC [8] = '{
    {1'b0, 1'b1, 32'h4000_0000, 32'h0000_0000},
    {1'b0, 1'b1, 32'h7FFF_FFFF, 32'h3FFF_FFFF},
    {1'b0, 1'b0, 32'h3FFF_FFFF, 32'h3FFF_FFFF},
    {1'b0, 1'b0, 32'h8000_0000, 32'h8000_0000},
    {1'b1, 1'b1, 32'hC000_1234, 32'h0000_1234},
    {1'b1, 1'b0, 32'h4000_0010, 32'h4000_0010},
    {1'b0, 1'b0, 32'hC000_0000, 32'hC000_0000},
    {1'b0, 1'b1, 32'h5A5A_5A5A, 32'h1A5A_5A5A}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 0;
  endtask

  task automatic rd_check(input string req, input logic [1:0] a, input logic [31:0] exp);
    @(negedge clk);
    cfg_addr = a;
    #1 check(req, cfg_rdata, exp);
  endtask

  task automatic req(input logic io, input logic [31:0] a);
    @(negedge clk);
    req_valid = 1; req_is_io = io; req_addr = a;
    #1;
  endtask

  initial begin
    #100000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R1 reset values
    for (int r = 0; r < 4; r++) rd_check("R1 reset read", 2'(r), 32'h0);
    req(0, 32'h0000_0000);
    check("R1 no hit after reset", {31'h0, hit}, 32'h0);

    // R11 range fully writable
    wr(2'd0, 32'h1234_5678);
    rd_check("R11 range readback", 2'd0, 32'h1234_5678);
    // R3 base low half ignored
    wr(2'd1, 32'hFFFF_FFFF);
    rd_check("R3 mem base readback", 2'd1, 32'hFFFF_0000);
    wr(2'd2, 32'hABCD_1234);
    rd_check("R3 io base readback", 2'd2, 32'hABCD_0000);
    // R4 remap reserved bits
    wr(2'd3, 32'hFFFF_FFFF);
    rd_check("R4 remap readback", 2'd3, 32'hFFFF_0017);

    // table configuration (R2 register map)
    wr(2'd0, 32'hC000_0000);
    wr(2'd1, 32'h4000_0000);
    wr(2'd2, 32'hC000_0000);
    wr(2'd3, 32'h0000_0017);
    for (int i = 0; i < 8; i++) begin
      req(VEC[i][65], VEC[i][63:32]);
      check($sformatf("R5/R6 hit vec%0d", i), {31'h0, hit}, {31'h0, VEC[i][64]});
      check($sformatf("R7/R8 addr vec%0d", i), pci_addr, VEC[i][31:0]);
    end

    // R9 lock and read mode
    req(0, 32'h4000_0000);
    check("R9 lock on hit", {31'h0, pci_lock}, 32'h1);
    check("R9 read mode", {31'h0, pci_rd_mode}, 32'h1);
    req(0, 32'h0000_0000);
    check("R9 no lock on miss", {31'h0, pci_lock}, 32'h0);

    // R7 nonzero remap
    wr(2'd3, 32'hA000_0001);
    req(0, 32'h4123_4567);
    check("R7 remap upper bits", pci_addr, 32'h8123_4567);
    check("R9 read mode clear", {31'h0, pci_rd_mode}, 32'h0);
    // R6 io disabled
    req(1, 32'hC000_0000);
    check("R6 io disabled no hit", {31'h0, hit}, 32'h0);
    check("R8 io disabled pass", pci_addr, 32'hC000_0000);
    // R5 memory disabled
    wr(2'd3, 32'h0000_0002);
    req(0, 32'h4000_0000);
    check("R5 mem disabled no hit", {31'h0, hit}, 32'h0);
    // R8 invalid request
    wr(2'd3, 32'h0000_0001);
    @(negedge clk); req_valid = 0; req_addr = 32'h4000_0000; #1;
    check("R8 idle no hit", {31'h0, hit}, 32'h0);

    // R10 same-cycle write uses old values
    req(0, 32'h4000_0000);
    cfg_wr_en = 1; cfg_addr = 2'd1; cfg_wdata = 32'h8000_0000;
    #1 check("R10 old base before edge", {31'h0, hit}, 32'h1);
    @(negedge clk); cfg_wr_en = 0; #1;
    check("R10 new base after edge", {31'h0, hit}, 32'h0);
    check("R2 write landed", cfg_rdata, 32'h8000_0000);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule